// File: doc/BRIEF.md
# SDRAM Command Spacing Timer

This block sits next to an SDRAM command sequencer and tells it when the next row activate may be issued. It watches the command stream and starts a countdown for three minimum spacings: activate-to-activate across banks, mode-register load to activate, and self-refresh exit to activate. While any of these countdowns is running, the single grant output is held low. The sequencer waits for the grant before it issues an activate.

The three spacing values sit in a small register port. All of them use an n+1 encoding, so a field value n gives a spacing of n+1 clock cycles. After reset every field holds all ones, which is the longest spacing. One set of values covers every chip select, so the countdowns are shared and do not depend on which device a command targets. Every register access takes exactly one wait state. A write that arrives while a countdown is running changes only the countdowns that start later.

Top module: `sdram_cmd_gap_timer`

## Requirements
- R1: After reset the fields read 0xF (address 0), 0xF (address 1) and 0x1F (address 2), and `act_ok_o` is high.
- R2: For an access presented with `reg_req_i` high in cycle t, `reg_ack_o` is high in cycle t+1 and only then. On a read, `reg_rdata_o` carries the data in that same cycle. On a write it carries zero.
- R3: Address 0 holds the activate-to-activate code in bits [3:0]. Address 1 holds the mode-load-to-activate code in bits [3:0]. Address 2 holds the self-refresh-exit code in bits [4:0]. Address 3 is reserved. All other bits, and the whole of address 3, read as zero, and writes to them are ignored.
- R4: An activate (`cmd_i`=1) seen in cycle t with activate code n holds `act_ok_o` low in cycles t+1 to t+n. The output may rise again in cycle t+n+1.
- R5: A mode-register load (`cmd_i`=2) seen in cycle t with code n holds `act_ok_o` low in cycles t+1 to t+n.
- R6: A self-refresh exit (`cmd_i`=3) seen in cycle t with code n holds `act_ok_o` low in cycles t+1 to t+n.
- R7: `act_ok_o` is high only when all three countdowns have expired. Overlapping spacings therefore combine to the latest end.
- R8: A trigger command that arrives while its own countdown is running restarts that countdown from its full value.
- R9: The chip select `cmd_cs_i` has no effect on timing. An activate to any chip select starts the same shared countdown.
- R10: A register write never changes a countdown that is already running. A trigger in the same cycle as a write to its field uses the value held before that write.
- R11: NOP (`cmd_i`=0) and the codes 4 to 7 start no countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request, one cycle per access |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid with the acknowledge |
| reg_ack_o | output | 1 | Access acknowledge, one cycle after the request |
| cmd_i | input | 3 | Observed command: 0 NOP, 1 activate, 2 mode load, 3 self-refresh exit |
| cmd_cs_i | input | 2 | Chip select of the observed command |
| act_ok_o | output | 1 | High when an activate may be issued |

## Verification
A register write and a trigger command can land in the same cycle. This is the case where the order of update matters: the countdown must start from the old field value, and the new value must apply only to the next trigger. The bench drives a write to the activate field together with an activate. It then issues a second activate and compares both spacings with a reference model that applies triggers before writes. The bench also changes a field in the middle of a countdown and checks that the grant still rises on the cycle the old value sets.

// File: rtl/sdram_gap_pkg.sv
package sdram_gap_pkg;
  localparam logic [2:0] CMD_NOP = 3'd0;
  localparam logic [2:0] CMD_ACT = 3'd1;
  localparam logic [2:0] CMD_LMR = 3'd2;
  localparam logic [2:0] CMD_SRX = 3'd3;

  localparam int NUM_GAPS = 3;
  localparam int GAP_RRD  = 0;
  localparam int GAP_MRD  = 1;
  localparam int GAP_XSR  = 2;

  localparam logic [1:0] ADDR_RRD  = 2'd0;
  localparam logic [1:0] ADDR_MRD  = 2'd1;
  localparam logic [1:0] ADDR_XSR  = 2'd2;
endpackage

// File: rtl/sdram_gap_counter.sv
module sdram_gap_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sdram_gap_regs.sv
module sdram_gap_regs
  import sdram_gap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RRD_W  = 4,
  parameter int MRD_W  = 4,
  parameter int XSR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  output logic [RRD_W-1:0]  rrd_o,
  output logic [MRD_W-1:0]  mrd_o,
  output logic [XSR_W-1:0]  xsr_o
);
  logic [RRD_W-1:0]  rrd_q;
  logic [MRD_W-1:0]  mrd_q;
  logic [XSR_W-1:0]  xsr_q;
  logic [DATA_W-1:0] rd_sel;
  logic [DATA_W-1:0] rdata_q;
  logic              ack_q;
  logic              wr;

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rrd_q <= '1;
      mrd_q <= '1;
      xsr_q <= '1;
    end else if (wr) begin
      case (addr_i)
        ADDR_RRD: rrd_q <= wdata_i[RRD_W-1:0];
        ADDR_MRD: mrd_q <= wdata_i[MRD_W-1:0];
        ADDR_XSR: xsr_q <= wdata_i[XSR_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_sel = '0;
    case (addr_i)
      ADDR_RRD: rd_sel[RRD_W-1:0] = rrd_q;
      ADDR_MRD: rd_sel[MRD_W-1:0] = mrd_q;
      ADDR_XSR: rd_sel[XSR_W-1:0] = xsr_q;
      default:  rd_sel = '0;
    endcase
  end

  // one wait state: acknowledge and read data registered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= req_i;
      rdata_q <= (req_i && !we_i) ? rd_sel : '0;
    end
  end

  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;
  assign rrd_o   = rrd_q;
  assign mrd_o   = mrd_q;
  assign xsr_o   = xsr_q;
endmodule

// File: rtl/sdram_cmd_gap_timer.sv
module sdram_cmd_gap_timer
  import sdram_gap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RRD_W  = 4,
  parameter int MRD_W  = 4,
  parameter int XSR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              reg_ack_o,
  input  logic [2:0]        cmd_i,
  input  logic [1:0]        cmd_cs_i,
  output logic              act_ok_o
);
  localparam int MAX_RM = (RRD_W > MRD_W) ? RRD_W : MRD_W;
  localparam int CNT_W  = (MAX_RM > XSR_W) ? MAX_RM : XSR_W;

  logic [RRD_W-1:0] cfg_rrd;
  logic [MRD_W-1:0] cfg_mrd;
  logic [XSR_W-1:0] cfg_xsr;

  logic [NUM_GAPS-1:0]            trig;
  logic [NUM_GAPS-1:0]            busy;
  logic [NUM_GAPS-1:0][CNT_W-1:0] load_val;

  // timing is shared across chip selects
  logic cs_unused;
  assign cs_unused = ^cmd_cs_i;

  sdram_gap_regs #(
    .DATA_W(DATA_W), .RRD_W(RRD_W), .MRD_W(MRD_W), .XSR_W(XSR_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (reg_req_i),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ack_o   (reg_ack_o),
    .rrd_o   (cfg_rrd),
    .mrd_o   (cfg_mrd),
    .xsr_o   (cfg_xsr)
  );

  assign trig[GAP_RRD] = (cmd_i == CMD_ACT);
  assign trig[GAP_MRD] = (cmd_i == CMD_LMR);
  assign trig[GAP_XSR] = (cmd_i == CMD_SRX);

  // code n -> n+1 cycle gap: load n, grant once counter returns to zero
  assign load_val[GAP_RRD] = CNT_W'(cfg_rrd);
  assign load_val[GAP_MRD] = CNT_W'(cfg_mrd);
  assign load_val[GAP_XSR] = CNT_W'(cfg_xsr);

  for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
    sdram_gap_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (trig[g]),
      .load_val_i (load_val[g]),
      .busy_o     (busy[g])
    );
  end

  assign act_ok_o = ~|busy;
endmodule

// File: rtl/sdram_gap_chk.sv
module sdram_gap_chk
  import sdram_gap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RRD_W  = 4,
  parameter int XSR_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              reg_ack_o,
  input logic [2:0]        cmd_i,
  input logic              act_ok_o,
  input logic [RRD_W-1:0]  cfg_rrd,
  input logic [XSR_W-1:0]  cfg_xsr
);
  p_ack_one_wait_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i |=> reg_ack_o);

  p_no_spurious_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_req_i |=> !reg_ack_o);

  p_rsvd_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i && reg_addr_i == 2'd3) |=> (reg_rdata_o == '0));

  p_act_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ACT && cfg_rrd != '0) |=> !act_ok_o);

  p_srx_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_SRX && cfg_xsr != '0) |=> !act_ok_o);

  p_idle_stays_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_ok_o && cmd_i != CMD_ACT && cmd_i != CMD_LMR && cmd_i != CMD_SRX) |=> act_ok_o);
endmodule

bind sdram_cmd_gap_timer sdram_gap_chk #(
  .DATA_W(DATA_W), .RRD_W(RRD_W), .XSR_W(XSR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_req_i   (reg_req_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .reg_ack_o   (reg_ack_o),
  .cmd_i       (cmd_i),
  .act_ok_o    (act_ok_o),
  .cfg_rrd     (cfg_rrd),
  .cfg_xsr     (cfg_xsr)
);

// File: tb/sim_sdram_cmd_gap_timer.sv
module sim_sdram_cmd_gap_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack;
  logic [2:0]  cmd = '0;
  logic [1:0]  cs = '0;
  logic        act_ok;

  int errors = 0, checks = 0, cyc_cnt = 0;
  string tag = "R1";

  // reference model
  int m_rrd, m_mrd, m_xsr;
  int u_rrd, u_mrd, u_xsr, cyc;
  bit e_ack;
  int e_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_gap_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .reg_ack_o(ack), .cmd_i(cmd), .cmd_cs_i(cs), .act_ok_o(act_ok)
  );

  function automatic int rd_model(input int a);
    case (a)
      0: return m_rrd;
      1: return m_mrd;
      2: return m_xsr;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rrd = 15; m_mrd = 15; m_xsr = 31;
      u_rrd = 0; u_mrd = 0; u_xsr = 0; cyc = 0;
      e_ack = 0; e_rd = 0;
    end else begin
      cyc = cyc + 1;
      if (cmd == 3'd1) u_rrd = cyc + m_rrd;
      if (cmd == 3'd2) u_mrd = cyc + m_mrd;
      if (cmd == 3'd3) u_xsr = cyc + m_xsr;
      e_ack = req;
      e_rd  = (req && !we) ? rd_model(int'(addr)) : 0;
      if (req && we) begin
        case (addr)
          2'd0: m_rrd = int'(wdata[3:0]);
          2'd1: m_mrd = int'(wdata[3:0]);
          2'd2: m_xsr = int'(wdata[4:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual=%0d expected=%0d", t, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      check(tag, "act_ok", int'(act_ok),
            int'(cyc >= u_rrd && cyc >= u_mrd && cyc >= u_xsr));
      check("R2", "ack", int'(ack), int'(e_ack));
      if (e_ack) check(tag, "rdata", int'(rdata), e_rd);
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input logic [2:0] c, input logic rq, input logic w,
                      input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    cmd = c; req = rq; we = w; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(3'd0, 1'b0, 1'b0, 2'd0, 32'd0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    step(3'd0, 1'b1, 1'b1, a, d);
  endtask

  task automatic rd(input logic [1:0] a);
    step(3'd0, 1'b1, 1'b0, a, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    tag = "R1";
    rd(0); rd(1); rd(2); idle(2);
    tag = "R3";
    wr(0, 32'hFFFF_FFF3); rd(0); wr(3, 32'hFFFF_FFFF); rd(3);
    wr(2, 32'hFFFF_FFE6); rd(2); wr(1, 32'hA5A5_A5A5); rd(1); idle(2);
    tag = "R4";
    step(3'd1, 0, 0, 0, 0); idle(6);
    wr(0, 32'd0); step(3'd1, 0, 0, 0, 0); idle(3);
    tag = "R5";
    step(3'd2, 0, 0, 0, 0); idle(8);
    tag = "R6";
    step(3'd3, 0, 0, 0, 0); idle(9);
    tag = "R7";
    wr(0, 32'd4); step(3'd3, 0, 0, 0, 0); idle(2);
    step(3'd1, 0, 0, 0, 0); step(3'd2, 0, 0, 0, 0); idle(10);
    tag = "R8";
    step(3'd1, 0, 0, 0, 0); idle(2); step(3'd1, 0, 0, 0, 0); idle(7);
    tag = "R9";
    for (int k = 0; k < 4; k++) begin
      cs = 2'(k); step(3'd1, 0, 0, 0, 0); idle(6);
    end
    cs = 2'd0;
    tag = "R10";
    wr(0, 32'd10); step(3'd1, 0, 0, 0, 0); idle(2); wr(0, 32'd1); idle(10);
    step(3'd1, 1'b1, 1'b1, 2'd0, 32'd6); idle(3); step(3'd1, 0, 0, 0, 0); idle(9);
    tag = "R11";
    for (int k = 4; k < 8; k++) step(3'(k), 0, 0, 0, 0);
    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule